// File: doc/BRIEF.md
# Grouped GPIO Interrupt Combiner

This block watches several ports of general-purpose input pins and folds them into a single interrupt request for the processor. Software picks which pins join the group and sets a polarity per pin, so that each pin counts as active either when high or when low. The active, enabled pins are then merged in one of two ways. In "any" mode one active pin is enough. In "all" mode every enabled pin must be active.

The merged result drives a status bit in one of two trigger modes. In edge mode the status bit is set on a rising edge of the merged result. It then stays set until software writes 1 to clear it. In level mode the status bit copies the merged result. The interrupt output is the status bit. Pins are asynchronous, so each one passes through a two-flop synchroniser before it is evaluated.

Software reaches the block through a plain single-cycle register port. Address 0 is the control word. Addresses 1 to NUM_PORTS hold the per-port polarity words. The next NUM_PORTS addresses hold the per-port enable words.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset every register reads 0 and irq_o is 0.
- R2: Polarity words (address 1+p) and enable words (address 1+NUM_PORTS+p) read back as written. Control bit 1 (combine: 0 any, 1 all) and bit 2 (trigger: 0 edge, 1 level) read back as written. Control bit 0 reads the status bit.
- R3: With combine bit 0, the group result is true when at least one enabled pin is active.
- R4: With combine bit 1, the group result is true when every enabled pin is active.
- R5: With no pin enabled, the group result is false in both combine modes.
- R6: A polarity bit of 1 makes its pin active when high. A polarity bit of 0 makes it active when low. Pin bit k of port p is pins_i[p*PORT_W+k].
- R7: In edge mode a rising edge of the group result sets the status bit. The bit stays set after the result falls.
- R8: In edge mode, writing control with bit 0 = 1 clears the status bit. Writing bit 0 = 0 leaves it unchanged.
- R9: When a clear write and a rising edge of the group result land on the same clock edge, the status bit ends up set.
- R10: In level mode the status bit equals the group result of the previous cycle, and writes to control bit 0 have no effect on it.
- R11: irq_o always equals the status bit read at control bit 0.
- R12: A pin change reaches irq_o on the third rising clock edge after it is applied (two synchroniser stages plus the status register), and not earlier.
- R13: A pin whose enable bit is 0 has no influence on the group result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*PORT_W | Asynchronous GPIO inputs, port p at bits [p*PORT_W +: PORT_W] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| irq_o | output | 1 | Group interrupt request |

## Verification
The hardest case to produce from the ports is a software clear that lands on the same clock edge as a fresh rising edge of the group result. The bench raises a pin, counts the two synchroniser edges, and places the clear write on the third edge, where the status set also happens. The combine and polarity logic is swept over every enable, polarity and pin value of a two-by-two-pin configuration in level mode, so each combination is visible on irq_o. Edge-mode stickiness and the exact three-edge latency are checked by sampling irq_o one cycle before and at the expected cycle.

// File: rtl/gpio_group_pkg.sv
package gpio_group_pkg;
  localparam int CTRL_STAT_BIT = 0;
  localparam int CTRL_ALL_BIT  = 1;
  localparam int CTRL_LVL_BIT  = 2;

  typedef enum logic {COMB_ANY = 1'b0, COMB_ALL = 1'b1} comb_mode_e;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_mode_e;

  typedef struct packed {
    trig_mode_e trig;
    comb_mode_e comb;
  } grp_cfg_t;
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gg_regs.sv
module gg_regs
  import gpio_group_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic                            status_i,
  output grp_cfg_t                        cfg_o,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] pol_o,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] en_o,
  output logic                            clr_o,
  output logic [DATA_W-1:0]               rdata_o
);
  localparam int POL_BASE = 1;
  localparam int EN_BASE  = 1 + NUM_PORTS;

  grp_cfg_t                         cfg_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0] pol_q, en_q;
  logic                             ctrl_sel;

  assign ctrl_sel = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{trig: TRIG_EDGE, comb: COMB_ANY};
      pol_q <= '0;
      en_q  <= '0;
    end else if (we_i) begin
      if (ctrl_sel) begin
        cfg_q.comb <= comb_mode_e'(wdata_i[CTRL_ALL_BIT]);
        cfg_q.trig <= trig_mode_e'(wdata_i[CTRL_LVL_BIT]);
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr_i == ADDR_W'(POL_BASE + p)) pol_q[p] <= wdata_i[PORT_W-1:0];
        if (addr_i == ADDR_W'(EN_BASE + p))  en_q[p]  <= wdata_i[PORT_W-1:0];
      end
    end
  end

  // write-one-to-clear strobe; trigger stage decides whether it applies
  assign clr_o = we_i && ctrl_sel && wdata_i[CTRL_STAT_BIT];

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel) begin
      rdata_o[CTRL_STAT_BIT] = status_i;
      rdata_o[CTRL_ALL_BIT]  = cfg_q.comb;
      rdata_o[CTRL_LVL_BIT]  = cfg_q.trig;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == ADDR_W'(POL_BASE + p)) rdata_o[PORT_W-1:0] = pol_q[p];
      if (addr_i == ADDR_W'(EN_BASE + p))  rdata_o[PORT_W-1:0] = en_q[p];
    end
  end

  assign cfg_o = cfg_q;
  assign pol_o = pol_q;
  assign en_o  = en_q;
endmodule

// File: rtl/gg_combine.sv
module gg_combine
  import gpio_group_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8
) (
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] pins_i,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] pol_i,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] en_i,
  input  comb_mode_e                       mode_i,
  output logic                             hit_o
);
  logic [NUM_PORTS-1:0] port_any, port_all, port_used;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] active;
    assign active       = en_i[p] & ~(pins_i[p] ^ pol_i[p]);
    assign port_any[p]  = |active;
    assign port_all[p]  = &(active | ~en_i[p]);
    assign port_used[p] = |en_i[p];
  end

  always_comb begin
    if (port_used == '0)        hit_o = 1'b0;
    else if (mode_i == COMB_ALL) hit_o = &port_all;
    else                         hit_o = |port_any;
  end
endmodule

// File: rtl/gg_trigger.sv
module gg_trigger
  import gpio_group_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  trig_mode_e mode_i,
  input  logic       clr_i,
  output logic       prev_o,
  output logic       status_o
);
  logic prev_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q <= hit_i;
      if (mode_i == TRIG_LEVEL) status_q <= hit_i;
      else                      status_q <= (hit_i & ~prev_q) | (status_q & ~clr_i); // set wins
    end
  end

  assign prev_o   = prev_q;
  assign status_o = status_q;
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpio_group_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 32,
  localparam int DATA_W   = (PORT_W > 3) ? PORT_W : 3,
  localparam int ADDR_W   = $clog2(2 * NUM_PORTS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic                        reg_we_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]           reg_wdata_i,
  output logic [DATA_W-1:0]           reg_rdata_o,
  output logic                        irq_o
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] pins_s, pol, en;
  grp_cfg_t cfg;
  logic     clr, hit, hit_prev, status, lvl_mode;

  gg_sync #(.W(NUM_PORTS * PORT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  gg_regs #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .status_i(status),
    .cfg_o   (cfg),
    .pol_o   (pol),
    .en_o    (en),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  gg_combine #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_comb (
    .pins_i(pins_s),
    .pol_i (pol),
    .en_i  (en),
    .mode_i(cfg.comb),
    .hit_o (hit)
  );

  gg_trigger u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .mode_i  (cfg.trig),
    .clr_i   (clr),
    .prev_o  (hit_prev),
    .status_o(status)
  );

  assign lvl_mode = (cfg.trig == TRIG_LEVEL);
  assign irq_o    = status;
endmodule

// File: rtl/gpio_group_irq_chk.sv
module gpio_group_irq_chk #(
  parameter int EN_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hit_i,
  input logic            prev_i,
  input logic            status_i,
  input logic            lvl_i,
  input logic            clr_i,
  input logic [EN_W-1:0] en_i
);
  AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lvl_i) |-> (status_i == $past(hit_i))); // R10

  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!lvl_i && hit_i && !prev_i) |-> status_i); // R7

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!lvl_i && status_i && !clr_i) |-> status_i); // R7

  AST_EDGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!lvl_i && clr_i && !(hit_i && !prev_i)) |-> !status_i); // R8

  AST_SET_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!lvl_i && clr_i && hit_i && !prev_i) |-> status_i); // R9

  AST_NONE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !hit_i); // R5
endmodule

bind gpio_group_irq gpio_group_irq_chk #(.EN_W(NUM_PORTS * PORT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hit_i   (hit),
  .prev_i  (hit_prev),
  .status_i(status),
  .lvl_i   (lvl_mode),
  .clr_i   (clr),
  .en_i    (en)
);

// File: tb/gpio_group_irq_test.sv
`timescale 1ns/1ps
module gpio_group_irq_test;
  localparam int NP = 2;
  localparam int PW = 2;
  localparam int DW = 3;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*PW-1:0] pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_group_irq #(.NUM_PORTS(NP), .PORT_W(PW)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a);
    #0.5;
    v = int'(rdata);
    addr = '0;
    #0.5;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit model(input int en, input int pol, input int pv, input int all);
    int act;
    act = en & ~(pv ^ pol) & 15;
    if (en == 0) return 1'b0;
    if (all != 0) return (act == en);
    return (act != 0);
  endfunction

  initial begin : wdog
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int v;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);

    // R2 readback
    wr(1, 2); wr(2, 1); wr(3, 3); wr(4, 2); wr(0, 6);
    wait_neg(4);
    rd(1, v); chk("R2 pol0", v, 2);
    rd(2, v); chk("R2 pol1", v, 1);
    rd(3, v); chk("R2 en0", v, 3);
    rd(4, v); chk("R2 en1", v, 2);
    rd(0, v); chk("R2 ctrl", v, 6);

    // R3 R4 R5 R6 R13 R10 R11 sweep in level mode
    for (int cm = 0; cm < 2; cm++) begin
      for (int en = 0; en < 16; en++) begin
        for (int pol = 0; pol < 16; pol++) begin
          wr(1, pol & 3); wr(2, pol >> 2); wr(3, en & 3); wr(4, en >> 2);
          wr(0, 4 | (cm << 1));
          for (int pv = 0; pv < 16; pv++) begin
            @(negedge clk);
            pins = 4'(pv);
            wait_neg(3);
            if (cm == 0) chk("R3 R6 R13 any", int'(irq), int'(model(en, pol, pv, cm)));
            else         chk("R4 R6 R13 all", int'(irq), int'(model(en, pol, pv, cm)));
            if (en == 0) chk("R5 none enabled", int'(irq), 0);
            if (pv == 15) begin
              rd(0, v);
              chk("R11 status bit", v & 1, int'(irq));
            end
          end
        end
      end
    end

    // R10 level: write to status bit ignored while result true
    wr(1, 1); wr(2, 0); wr(3, 1); wr(4, 0); wr(0, 4);
    @(negedge clk); pins = 4'b0001;
    wait_neg(4);
    chk("R10 level true", int'(irq), 1);
    wr(0, 5);
    chk("R10 clear ignored", int'(irq), 1);
    // R12 latency in level mode
    pins = 4'b0000;
    wait_neg(2);
    chk("R12 not before third edge", int'(irq), 1);
    wait_neg(1);
    chk("R12 at third edge", int'(irq), 0);

    // edge mode, OR, pin0 active-high
    wr(0, 0);
    wait_neg(3);
    chk("R7 idle", int'(irq), 0);
    pins = 4'b0001;
    wait_neg(2);
    chk("R12 edge not yet", int'(irq), 0);
    wait_neg(1);
    chk("R7 R12 edge set", int'(irq), 1);
    pins = 4'b0000;
    wait_neg(4);
    chk("R7 sticky", int'(irq), 1);
    wr(0, 0);
    chk("R8 write zero keeps", int'(irq), 1);
    rd(0, v); chk("R11 ctrl read", v, 1);
    wr(0, 1);
    chk("R8 clear", int'(irq), 0);
    rd(0, v); chk("R8 ctrl read", v, 0);
    wait_neg(3);
    chk("R7 no re-set without edge", int'(irq), 0);

    // R9 clear and rising edge on the same clock edge
    pins = 4'b0001;          // applied before edge k
    @(posedge clk);          // k: stage 1
    @(negedge clk);          // after k+1 comes next
    @(posedge clk);          // k+1: stage 2, result rises
    @(negedge clk);
    addr = '0; wdata = 3'b001; we = 1'b1;
    @(negedge clk);          // edge k+2: set and clear together
    we = 1'b0; wdata = '0;
    chk("R9 set beats clear", int'(irq), 1);
    wr(0, 1);
    chk("R9 later clear", int'(irq), 0);

    // R4 R6 R7 edge mode, all-combine, pin1 active-low
    pins = 4'b0000;
    wr(1, 1); wr(3, 3); wr(0, 2);
    wait_neg(4);
    wr(0, 3);
    chk("R4 all not met", int'(irq), 0);
    pins = 4'b0011;
    wait_neg(4);
    chk("R4 pin1 high blocks", int'(irq), 0);
    pins = 4'b0001;
    wait_neg(3);
    chk("R4 R7 all met", int'(irq), 1);
    // R13 disabled port-1 pins toggle, state unchanged
    pins = 4'b1101;
    wait_neg(3);
    chk("R13 disabled pins", int'(irq), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule